// File: doc/BRIEF.md
# Striped Address Mapper for Up to Three Memory Channels

This block takes a flat 32-bit byte address and decides which of up to three independent memory channels owns it, and where inside that channel the byte lives. The address space is cut into 128-byte blocks. Successive blocks go to the populated channels in turn, so a linear sweep spreads evenly over every channel. Each channel still sees a dense, gap-free local address space.

A static setting gives the number of populated channels: channel 0 alone, channels 0 and 1, or all three. With three channels the block number has to be split by three, which needs a true divide and remainder rather than a bit slice. A second static setting gives the installed size in 128-byte blocks. The size is capped at 2 GB. A request at or beyond the installed size is flagged out of range, and no channel is selected for it. Requests enter and leave through valid/ready handshakes. There is a single register stage, and its latency is the same for every channel count.

Top module: `addr_stripe_map`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `in_ready` are 0. `in_ready` stays 0 for the first two rising edges after `rst_n` goes high.
- R2: When `cfg_chan_cnt` is 1 and the request is in range, `out_sel` is 3'b001 and `out_addr` equals the request address.
- R3: When `cfg_chan_cnt` is 2 and the request is in range, let B = addr[31:7]. The channel is B mod 2 (`out_sel` bit B[0] is set), and `out_addr` is {B/2, addr[6:0]}. Channel 2 is never selected.
- R4: When `cfg_chan_cnt` is 3 and the request is in range, the channel is B mod 3, and `out_addr` is {B/3, addr[6:0]} with zeros in the upper bits. Exactly one bit of `out_sel` is set.
- R5: A `cfg_chan_cnt` value of 0 behaves exactly like 1, which is a single channel.
- R6: When B is greater than or equal to the effective block limit, `out_oor` is 1 and `out_sel` and `out_addr` are all zero. Otherwise `out_oor` is 0.
- R7: The effective block limit is `cfg_size_blk` capped at 2^24 blocks (2 GB). Any address at or above 0x8000_0000 is therefore always out of range.
- R8: A request accepted on a rising edge appears on the outputs right after that edge, for every channel count. While `out_valid` is high and `out_ready` is low, all outputs hold their values.
- R9: Once reset has completed, `in_ready` equals `!out_valid || out_ready`, so one request per cycle flows through when the downstream side is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle |
| in_addr | input | 32 | Flat byte address |
| cfg_chan_cnt | input | 2 | Populated channels: 0 or 1 = one, 2 = two, 3 = three |
| cfg_size_blk | input | 25 | Installed size in 128-byte blocks |
| out_valid | output | 1 | Mapped result present |
| out_ready | input | 1 | Downstream accepts the result |
| out_sel | output | 3 | One-hot channel select, zero when out of range |
| out_addr | output | 32 | Address local to the selected channel |
| out_oor | output | 1 | Request beyond installed memory |

## Verification
The bench goes after the block numbers that sit next to the size limit and next to the 2 GB cap. A design with an off-by-one compare, or with a missing cap, would map the first block past the end, or wrap it onto channel 0. Long sweeps with three channels cross many multiples of three. A faulty remainder or quotient would send blocks to the wrong channel, or give two blocks the same local address. Random backpressure shows whether the result register drops or repeats a request when ready is low. A channel count of 0 is also driven, to catch a design that divides by zero or selects nothing.

// File: rtl/stripe_pkg.sv
package stripe_pkg;
  localparam int NCH = 3;
  typedef enum logic [1:0] {
    CNT_ZERO  = 2'd0,
    CNT_ONE   = 2'd1,
    CNT_TWO   = 2'd2,
    CNT_THREE = 2'd3
  } chan_cnt_e;
endpackage

// File: rtl/stripe_divmod3.sv
module stripe_divmod3 #(
  parameter int W = 25
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] quo,
  output logic [1:0]   rem
);
  logic [1:0] r [W:0];

  assign r[W] = 2'd0;

  for (genvar i = W - 1; i >= 0; i--) begin : g_step
    logic [2:0] part;
    logic       ge;
    assign part   = {r[i+1], val[i]};
    assign ge     = (part >= 3'd3);
    assign quo[i] = ge;
    assign r[i]   = ge ? 2'(part - 3'd3) : part[1:0];
  end

  assign rem = r[0];
endmodule

// File: rtl/stripe_route.sv
module stripe_route
  import stripe_pkg::*;
#(
  parameter int BLK_W = 25,
  parameter int OFS_W = 7
) (
  input  logic [BLK_W-1:0]       blk,
  input  logic [OFS_W-1:0]       ofs,
  input  logic [1:0]             cnt,
  input  logic [BLK_W-1:0]       size_blk,
  output logic [NCH-1:0]         sel,
  output logic [BLK_W+OFS_W-1:0] loc,
  output logic                   oor
);
  localparam logic [BLK_W-1:0] CAP_BLK = BLK_W'(1) << (BLK_W - 1);

  logic [BLK_W-1:0] q3;
  logic [1:0]       r3;
  logic [BLK_W-1:0] lim_eff;
  logic [BLK_W-1:0] lblk;
  logic [1:0]       idx;

  stripe_divmod3 #(.W(BLK_W)) u_div3 (
    .val (blk),
    .quo (q3),
    .rem (r3)
  );

  always_comb begin
    lim_eff = (size_blk > CAP_BLK) ? CAP_BLK : size_blk;
    oor     = (blk >= lim_eff);
    case (chan_cnt_e'(cnt))
      CNT_THREE: begin
        idx  = r3;
        lblk = q3;
      end
      CNT_TWO: begin
        idx  = {1'b0, blk[0]};
        lblk = blk >> 1;
      end
      default: begin
        idx  = 2'd0;
        lblk = blk;
      end
    endcase
    sel = '0;
    loc = '0;
    if (!oor) begin
      sel[idx] = 1'b1;
      loc      = {lblk, ofs};
    end
  end
endmodule

// File: rtl/stripe_oreg.sv
module stripe_oreg #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q, vld_d;
  logic [W-1:0] dat_q;
  logic         load;

  assign in_ready = run && (!vld_q || out_ready);
  assign load     = in_valid && in_ready;

  always_comb begin
    vld_d = vld_q;
    if (in_ready) vld_d = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) dat_q <= in_data;
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
endmodule

// File: rtl/addr_stripe_map.sv
module addr_stripe_map
  import stripe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 7,
  parameter int BLK_W  = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        cfg_chan_cnt,
  input  logic [BLK_W-1:0]  cfg_size_blk,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NCH-1:0]    out_sel,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_oor
);
  localparam int DW = NCH + ADDR_W + 1;

  logic [1:0]        rst_sync;
  logic              run;
  logic [NCH-1:0]    m_sel;
  logic [ADDR_W-1:0] m_loc;
  logic              m_oor;
  logic [DW-1:0]     o_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign run = rst_sync[1];

  stripe_route #(.BLK_W(BLK_W), .OFS_W(OFS_W)) u_route (
    .blk      (in_addr[ADDR_W-1:OFS_W]),
    .ofs      (in_addr[OFS_W-1:0]),
    .cnt      (cfg_chan_cnt),
    .size_blk (cfg_size_blk),
    .sel      (m_sel),
    .loc      (m_loc),
    .oor      (m_oor)
  );

  stripe_oreg #(.W(DW)) u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({m_sel, m_loc, m_oor}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (o_data)
  );

  assign {out_sel, out_addr, out_oor} = o_data;
endmodule

// File: rtl/stripe_chk.sv
module stripe_chk #(
  parameter int ADDR_W = 32,
  parameter int NCH    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        cfg_chan_cnt,
  input logic              out_valid,
  input logic              out_ready,
  input logic [NCH-1:0]    out_sel,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_oor
);
  localparam logic [ADDR_W-1:0] CAP_BYTES = ADDR_W'(1) << (ADDR_W - 1);

  AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_oor |-> $countones(out_sel) == 1); // R4
  AST_OOR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_oor |-> out_sel == '0 && out_addr == '0); // R6
  AST_LOCAL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_oor |-> out_addr < CAP_BYTES); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sel) && $stable(out_addr) && $stable(out_oor)); // R8
  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R9
  AST_TWO_CH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_chan_cnt == 2'd2 |-> !out_sel[2]); // R3
  AST_SINGLE_CH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_oor && cfg_chan_cnt < 2'd2 |-> out_sel == 3'b001); // R5
endmodule

bind addr_stripe_map stripe_chk #(.ADDR_W(ADDR_W), .NCH(stripe_pkg::NCH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .cfg_chan_cnt (cfg_chan_cnt),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_sel      (out_sel),
  .out_addr     (out_addr),
  .out_oor      (out_oor)
);

// File: tb/tb_addr_stripe_map.sv
`timescale 1ns/1ps
module tb_addr_stripe_map;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_addr;
  logic [1:0]  cfg_chan_cnt;
  logic [24:0] cfg_size_blk;
  logic        out_valid;
  logic        out_ready;
  logic [2:0]  out_sel;
  logic [31:0] out_addr;
  logic        out_oor;

  int total = 0;
  int bad   = 0;
  string req = "R2";

  logic        mv;
  logic [2:0]  msel;
  logic [31:0] maddr;
  logic        moor;

  addr_stripe_map dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .cfg_chan_cnt(cfg_chan_cnt), .cfg_size_blk(cfg_size_blk),
    .out_valid(out_valid), .out_ready(out_ready), .out_sel(out_sel),
    .out_addr(out_addr), .out_oor(out_oor)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic ref_map(input logic [31:0] a, output logic [2:0] s, output logic [31:0] l, output logic o);
    longint blk, lim, n;
    blk = longint'(a >> 7);
    n   = (cfg_chan_cnt == 2'd0) ? 1 : longint'(cfg_chan_cnt);
    lim = longint'(cfg_size_blk);
    if (lim > (64'd1 << 24)) lim = 64'd1 << 24;
    o = (blk >= lim);
    s = o ? 3'b000 : 3'(1 << (blk % n));
    l = o ? 32'd0 : 32'(((blk / n) << 7) | longint'(a & 32'h7F));
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic rdy);
    logic rexp;
    in_valid  = v;
    in_addr   = a;
    out_ready = rdy;
    #1;
    rexp = !mv || rdy;
    chk("R9", "in_ready", in_ready, rexp);
    if (rexp) begin
      mv = v;
      if (v) ref_map(a, msel, maddr, moor);
    end
    @(negedge clk);
    chk("R8", "out_valid", out_valid, mv);
    if (mv) begin
      chk(req, "out_sel", out_sel, msel);
      chk(req, "out_addr", out_addr, maddr);
      chk(req, "out_oor", out_oor, moor);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) step(1'b0, 32'd0, 1'b1);
  endtask

  task automatic sweep(input int n, input logic [31:0] base, input logic rnd_bp);
    for (int i = 0; i < n; i++)
      step(rnd_bp ? 1'($urandom % 4 != 0) : 1'b1, base + 32'(i) * 32'd128 + 32'($urandom % 128),
           rnd_bp ? 1'($urandom % 3 != 0) : 1'b1);
  endtask

  initial begin
    #20000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; out_ready = 1'b1;
    cfg_chan_cnt = 2'd1; cfg_size_blk = 25'h1FF_FFFF; mv = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", out_valid, 0);
    chk("R1", "in_ready in reset", in_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "in_ready edge 1", in_ready, 0);
    @(negedge clk);
    chk("R1", "in_ready after sync", in_ready, 1);

    req = "R2"; cfg_chan_cnt = 2'd1; sweep(200, 32'h0, 1'b0);
    step(1'b1, 32'h7FFF_FFC3, 1'b1);
    drain();
    req = "R3"; cfg_chan_cnt = 2'd2; sweep(200, 32'h1234_0000, 1'b0);
    drain();
    req = "R4"; cfg_chan_cnt = 2'd3; sweep(400, 32'h0, 1'b0);
    sweep(300, 32'h7FFF_0000, 1'b0);
    drain();
    req = "R5"; cfg_chan_cnt = 2'd0; sweep(100, 32'h0040_0000, 1'b0);
    drain();

    req = "R6";
    for (int c = 0; c < 4; c++) begin
      cfg_chan_cnt = 2'(c); cfg_size_blk = 25'd3000 + 25'(c);
      drain();
      step(1'b1, (32'(cfg_size_blk) - 1) * 128 + 32'd127, 1'b1);
      step(1'b1, 32'(cfg_size_blk) * 128, 1'b1);
      step(1'b1, 32'(cfg_size_blk) * 128 + 32'd5, 1'b1);
      step(1'b1, 32'hFFFF_FFFF, 1'b1);
    end
    drain();

    req = "R7"; cfg_size_blk = 25'h1FF_FFFF;
    for (int c = 1; c < 4; c++) begin
      cfg_chan_cnt = 2'(c);
      drain();
      step(1'b1, 32'h7FFF_FF80, 1'b1);
      step(1'b1, 32'h8000_0000, 1'b1);
      step(1'b1, 32'hC000_1234, 1'b1);
    end
    drain();

    req = "R8";
    for (int c = 0; c < 4; c++) begin
      cfg_chan_cnt = 2'(c); cfg_size_blk = 25'(24'hFF_FFF0 + 24'($urandom % 32));
      drain();
      sweep(2000, 32'h7F00_0000, 1'b1);
      drain();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule